// File: doc/BRIEF.md
# Half-Duplex Backoff Controller

This block decides when a shared-medium Ethernet transmitter may put a frame on the wire, and what it does when that attempt fails. It runs on the nibble clock, so one clock is four bit times. When a frame is pending, the block holds off while the receive carrier is present and then enforces the interframe gap. After that it raises a go level that tells the frame assembler to stream the frame. In full-duplex operation the carrier is ignored and only the gap applies.

A collision seen while the go level is high ends the attempt. The block then drives a fixed jam pattern for 32 bit times, counts the collision and waits a random number of slot times before it retries. The random count mixes a free-running 10-bit maximal-length LFSR with the low bits of the current transmit data. It is truncated to as many bits as there have been collisions, up to ten. After the sixteenth collision of one frame, the block gives up and pulses an error.

For half-duplex flow control, a back-pressure option makes the block drive the same nibble pattern for 64 bit times whenever a new incoming frame appears on the carrier while it is idle. This forces a collision on the remote station.

Top module: `csma_backoff_ctrl`

## Requirements
- R1: While reset is held low, `tx_go`, `jam_en`, `force_en`, `tx_done` and `tx_err` are 0 and `tx_nib` is 4'b0000.
- R2: With `full_duplex` high, `tx_go` rises exactly IFG_NIB+1 clocks after `tx_req` is first sampled high in idle, whatever `crs` does. `col` never starts a jam in this mode.
- R3: With `full_duplex` low, `tx_go` stays low while `crs` is high. It rises after IFG_NIB consecutive clock edges in which `crs` is sampled low, and any high sample of `crs` restarts that count.
- R4: A `col` sampled high while `tx_go` is high in half-duplex mode drops `tx_go` and raises `jam_en` on the next clock. `jam_en` then stays high for exactly JAM_NIB (8) clocks, with `tx_nib` = 4'b1011.
- R5: After the n-th collision of a frame, with `crs` low, the number of clocks between the last jam clock and the next `tx_go` is 1 + k*SLOT_NIB + IFG_NIB, with 0 <= k < 2^min(n,10).
- R6: The jam that follows the 16th collision of one frame is followed on the next clock by a one-clock `tx_err` pulse, and the frame is not retried. No earlier jam of that frame is followed by `tx_err`.
- R7: `frame_end` sampled high while `tx_go` is high ends the frame: `tx_done` pulses on the next clock and `tx_go` falls. The collision count restarts, so a later frame again needs 16 collisions before `tx_err`.
- R8: In half-duplex mode with `bp_en` high and the block idle, a rising `crs` raises `force_en` on the next clock for exactly BP_NIB (16) clocks, with `tx_nib` = 4'b1011. A `crs` that stays high does not retrigger it, and it never occurs with `full_duplex` high or `bp_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | 1 = full duplex, carrier and collision ignored |
| bp_en | input | 1 | Enables forced collisions on incoming frames |
| tx_req | input | 1 | A frame is pending; held until done or error |
| frame_end | input | 1 | Assembler has sent the last nibble of the frame |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| data_lsb | input | BO_BITS | Low bits of the current transmit data word |
| tx_go | output | 1 | Assembler may stream the frame |
| jam_en | output | 1 | Jam pattern on `tx_nib` |
| force_en | output | 1 | Back-pressure pattern on `tx_nib` |
| tx_nib | output | 4 | Pattern nibble, zero when neither is active |
| tx_done | output | 1 | One-clock pulse: frame sent |
| tx_err | output | 1 | One-clock pulse: retry limit reached |

## Verification
Each result is due a fixed number of clocks after the edge that samples its cause. `tx_go` comes IFG_NIB+1 edges after a request in full duplex, and IFG_NIB edges after carrier drops. Jam and force start one edge after the collision or the carrier rise, and `tx_done` and `tx_err` appear one edge after the frame end or the last jam clock. The bench drives and samples on the falling edge and counts the rising edges in between, so each check lands in the exact clock its requirement names. Backoff gaps hold a random factor, so they are checked against the legal set of lengths for the current collision number rather than against one value.

// File: rtl/csma_pkg.sv
package csma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_TX,
      ST_JAM,
      ST_BACKOFF,
      ST_FORCE
   } csma_state_e;

   // Feedback tap mask of a maximal-length Fibonacci LFSR; 0 = width unsupported
   function automatic logic [15:0] lfsr_taps(input int w);
      case (w)
         8:       return 16'h00B8;
         9:       return 16'h0110;
         10:      return 16'h0240;
         11:      return 16'h0500;
         12:      return 16'h0E08;
         16:      return 16'hD008;
         default: return 16'h0000;
      endcase
   endfunction

endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] q
);
   localparam logic [15:0] TAPS = csma_pkg::lfsr_taps(W);

   generate
      if (TAPS == 16'h0000) begin : g_bad_width
         initial $error("csma_lfsr: width %0d has no tap set", W);
      end
   endgenerate

   logic fb;
   assign fb = ^(q & TAPS[W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= W'(1);
      else        q <= {q[W-2:0], fb};
   end
endmodule

// File: rtl/csma_slot_pick.sv
module csma_slot_pick #(
   parameter int B  = 10,
   parameter int CW = 5
) (
   input  logic [CW-1:0] coll_n,
   input  logic [B-1:0]  rnd,
   input  logic [B-1:0]  seed,
   output logic [B-1:0]  slots
);
   logic [B-1:0] mask;

   // bit i survives once at least i+1 collisions have been seen
   generate
      for (genvar i = 0; i < B; i++) begin : g_mask
         assign mask[i] = (32'(coll_n) > i);
      end
   endgenerate

   assign slots = (rnd ^ seed) & mask;
endmodule

// File: rtl/csma_backoff_ctrl.sv
module csma_backoff_ctrl #(
   parameter int          BO_BITS      = 10,
   parameter int          IFG_NIB      = 24,
   parameter int          SLOT_NIB     = 128,
   parameter int          JAM_NIB      = 8,
   parameter int          BP_NIB       = 16,
   parameter int          MAX_ATTEMPTS = 16,
   parameter logic [3:0]  PATTERN      = 4'b1011
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               full_duplex,
   input  logic               bp_en,
   input  logic               tx_req,
   input  logic               frame_end,
   input  logic               crs,
   input  logic               col,
   input  logic [BO_BITS-1:0] data_lsb,
   output logic               tx_go,
   output logic               jam_en,
   output logic               force_en,
   output logic [3:0]         tx_nib,
   output logic               tx_done,
   output logic               tx_err
);
   import csma_pkg::*;

   localparam int SEQ_MAX = (JAM_NIB > BP_NIB) ? JAM_NIB : BP_NIB;
   localparam int CW      = $clog2(MAX_ATTEMPTS + 1);
   localparam int GW      = (IFG_NIB  > 1) ? $clog2(IFG_NIB)  : 1;
   localparam int SW      = (SLOT_NIB > 1) ? $clog2(SLOT_NIB) : 1;
   localparam int QW      = (SEQ_MAX  > 1) ? $clog2(SEQ_MAX)  : 1;

   initial begin : elab_chk
      assert (IFG_NIB >= 2)      else $error("IFG_NIB must be at least 2");
      assert (SLOT_NIB >= 2)     else $error("SLOT_NIB must be at least 2");
      assert (JAM_NIB >= 1)      else $error("JAM_NIB must be at least 1");
      assert (BP_NIB >= 1)       else $error("BP_NIB must be at least 1");
      assert (MAX_ATTEMPTS >= 1) else $error("MAX_ATTEMPTS must be at least 1");
   end

   csma_state_e        state;
   logic [GW-1:0]      gap_cnt;
   logic [SW-1:0]      slot_cnt;
   logic [QW-1:0]      seq_cnt;
   logic [BO_BITS-1:0] bo_left;
   logic [CW-1:0]      coll_cnt;
   logic               crs_q;
   logic [BO_BITS-1:0] rnd;
   logic [BO_BITS-1:0] pick;
   logic [CW-1:0]      coll_next;
   logic               quiet;
   logic               crs_rise;

   csma_lfsr #(.W(BO_BITS)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .q     (rnd)
   );

   assign coll_next = coll_cnt + 1'b1;

   csma_slot_pick #(.B(BO_BITS), .CW(CW)) u_pick (
      .coll_n (coll_next),
      .rnd    (rnd),
      .seed   (data_lsb),
      .slots  (pick)
   );

   assign quiet    = full_duplex | ~crs;
   assign crs_rise = crs & ~crs_q;

   always_comb begin
      tx_go    = (state == ST_TX);
      jam_en   = (state == ST_JAM);
      force_en = (state == ST_FORCE);
      tx_nib   = (jam_en | force_en) ? PATTERN : 4'b0000;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         gap_cnt  <= '0;
         slot_cnt <= '0;
         seq_cnt  <= '0;
         bo_left  <= '0;
         coll_cnt <= '0;
         crs_q    <= 1'b0;
         tx_done  <= 1'b0;
         tx_err   <= 1'b0;
      end else begin
         crs_q   <= crs;
         tx_done <= 1'b0;
         tx_err  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (bp_en && !full_duplex && crs_rise) begin
                  state   <= ST_FORCE;
                  seq_cnt <= '0;
               end else if (tx_req) begin
                  state   <= ST_WAIT;
                  gap_cnt <= '0;
               end
            end
            ST_WAIT: begin
               if (!quiet)                              gap_cnt <= '0;
               else if (gap_cnt == GW'(IFG_NIB - 1))    state   <= ST_TX;
               else                                     gap_cnt <= gap_cnt + 1'b1;
            end
            ST_TX: begin
               if (col && !full_duplex) begin
                  state    <= ST_JAM;
                  seq_cnt  <= '0;
                  coll_cnt <= coll_next;
                  bo_left  <= pick;
               end else if (frame_end) begin
                  state    <= ST_IDLE;
                  tx_done  <= 1'b1;
                  coll_cnt <= '0;
               end
            end
            ST_JAM: begin
               if (seq_cnt == QW'(JAM_NIB - 1)) begin
                  if (coll_cnt == CW'(MAX_ATTEMPTS)) begin
                     state    <= ST_IDLE;
                     tx_err   <= 1'b1;
                     coll_cnt <= '0;
                  end else begin
                     state    <= ST_BACKOFF;
                     slot_cnt <= '0;
                  end
               end else begin
                  seq_cnt <= seq_cnt + 1'b1;
               end
            end
            ST_BACKOFF: begin
               if (bo_left == '0) begin
                  state   <= ST_WAIT;
                  gap_cnt <= '0;
               end else if (slot_cnt == SW'(SLOT_NIB - 1)) begin
                  slot_cnt <= '0;
                  bo_left  <= bo_left - 1'b1;
               end else begin
                  slot_cnt <= slot_cnt + 1'b1;
               end
            end
            ST_FORCE: begin
               if (seq_cnt == QW'(BP_NIB - 1)) state   <= ST_IDLE;
               else                            seq_cnt <= seq_cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_GO_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_go) && !$past(full_duplex)) |-> !$past(crs)); // R3

   AST_JAM_FROM_COL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jam_en) |-> ($past(col) && $past(tx_go) && !$past(full_duplex))); // R4

   AST_ERR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      tx_err |-> ($past(coll_cnt) == CW'(MAX_ATTEMPTS))); // R6

   AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done || tx_err) |-> (coll_cnt == '0)); // R7

   AST_FORCE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(force_en) |-> ($past(crs) && !$past(crs_q) && $past(bp_en) && !$past(full_duplex))); // R8

   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_go, jam_en, force_en})); // R4
endmodule

// File: tb/sim_csma_backoff_ctrl.sv
`timescale 1ns/1ps
module sim_csma_backoff_ctrl;
   localparam int BOB  = 10;
   localparam int IFG  = 24;
   localparam int SLOT = 4;
   localparam int JAM  = 8;
   localparam int BP   = 16;
   localparam int MAXA = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0, full_duplex = 1'b0, bp_en = 1'b0, tx_req = 1'b0;
   logic frame_end = 1'b0, crs = 1'b0, col = 1'b0;
   logic [BOB-1:0] data_lsb = '0;
   logic tx_go, jam_en, force_en, tx_done, tx_err;
   logic [3:0] tx_nib;

   int checks = 0;
   int errors = 0;

   csma_backoff_ctrl #(
      .BO_BITS(BOB), .IFG_NIB(IFG), .SLOT_NIB(SLOT),
      .JAM_NIB(JAM), .BP_NIB(BP), .MAX_ATTEMPTS(MAXA)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .bp_en(bp_en),
      .tx_req(tx_req), .frame_end(frame_end), .crs(crs), .col(col),
      .data_lsb(data_lsb), .tx_go(tx_go), .jam_en(jam_en), .force_en(force_en),
      .tx_nib(tx_nib), .tx_done(tx_done), .tx_err(tx_err)
   );

   initial forever begin
      @(negedge clk);
      data_lsb = BOB'($urandom());
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wait_go(output int n);
      n = 0;
      while (!tx_go) begin tick(); n++; end
   endtask

   // legal backoff gap for collision number n
   function automatic bit gap_ok(input int g, input int n);
      int k, lim;
      lim = 1 << ((n < 10) ? n : 10);
      if (g < 1 + IFG) return 1'b0;
      if (((g - 1 - IFG) % SLOT) != 0) return 1'b0;
      k = (g - 1 - IFG) / SLOT;
      return (k < lim);
   endfunction

   task automatic end_frame(input string req);
      frame_end = 1'b1;
      tick();
      frame_end = 1'b0;
      tx_req = 1'b0;
      chk(tx_done && !tx_go, req, {tx_done, tx_go}, 2);
      tick();
      chk(!tx_done, req, tx_done, 0);
   endtask

   // collide the current attempt (n-th collision of this frame)
   task automatic collide(input int n, input string req_err);
      int len, g;
      col = 1'b1;
      tick();
      col = 1'b0;
      chk(jam_en && !tx_go && tx_nib == 4'b1011, "R4 jam start", tx_nib, 11);
      len = 0;
      while (jam_en) begin len++; tick(); end
      chk(len == JAM, "R4 jam length", len, JAM);
      if (n == MAXA) begin
         chk(tx_err, "R6 error pulse", tx_err, 1);
      end else begin
         chk(!tx_err, req_err, tx_err, 0);
         g = 0;
         while (!tx_go) begin g++; tick(); end
         chk(gap_ok(g, n), "R5 backoff gap", g, 1 + IFG);
      end
   endtask

   initial begin
      int n, d, len;
      bit bad;
      void'($urandom(32'd4242));
      repeat (3) tick();
      // R1 reset state
      chk(!tx_go && !jam_en && !force_en && !tx_done && !tx_err && tx_nib == 4'd0,
          "R1 reset", {tx_go, jam_en, force_en, tx_done, tx_err}, 0);
      rst_n = 1'b1;
      tick();

      // R2 full duplex: carrier ignored, collision ignored
      full_duplex = 1'b1; crs = 1'b1; tx_req = 1'b1;
      wait_go(n);
      chk(n == IFG + 1, "R2 start delay", n, IFG + 1);
      col = 1'b1;
      bad = 1'b0;
      repeat (4) begin tick(); if (jam_en || !tx_go) bad = 1'b1; end
      col = 1'b0;
      chk(!bad, "R2 collision ignored", bad, 0);
      end_frame("R7 done full duplex");
      crs = 1'b0; full_duplex = 1'b0;
      tick();

      // R3 half duplex deferral, random lengths, some with a carrier glitch
      for (int it = 0; it < 5; it++) begin
         crs = 1'b1; tx_req = 1'b1;
         d = $urandom_range(10, 60);
         bad = 1'b0;
         repeat (d) begin tick(); if (tx_go) bad = 1'b1; end
         if (it % 2 == 1) begin
            crs = 1'b0;
            repeat ($urandom_range(2, IFG - 2)) begin tick(); if (tx_go) bad = 1'b1; end
            crs = 1'b1;
            tick();
         end
         chk(!bad, "R3 held off by carrier", bad, 0);
         crs = 1'b0;
         wait_go(n);
         chk(n == IFG, "R3 gap after carrier", n, IFG);
         end_frame("R7 done half duplex");
      end

      // R5/R7: a few collisions then success, clearing the count
      for (int it = 0; it < 3; it++) begin
         tx_req = 1'b1;
         wait_go(n);
         d = $urandom_range(1, 4);
         for (int c = 1; c <= d; c++) collide(c, "R6 no early error");
         end_frame("R7 done after retries");
      end

      // R6/R7: full retry limit on the next frame
      tx_req = 1'b1;
      wait_go(n);
      for (int c = 1; c <= MAXA; c++) collide(c, "R7 count restarted");
      tx_req = 1'b0;
      tick();
      chk(!tx_err, "R6 error is one pulse", tx_err, 0);
      bad = 1'b0;
      repeat (40) begin tick(); if (tx_go || jam_en) bad = 1'b1; end
      chk(!bad, "R6 no retry after limit", bad, 0);

      // R8 back pressure
      bp_en = 1'b1;
      crs = 1'b1;
      tick();
      chk(force_en && tx_nib == 4'b1011, "R8 force start", tx_nib, 11);
      len = 0;
      bad = 1'b0;
      while (force_en) begin if (tx_nib != 4'b1011) bad = 1'b1; len++; tick(); end
      chk(len == BP && !bad, "R8 force length", len, BP);
      bad = 1'b0;
      repeat (20) begin tick(); if (force_en) bad = 1'b1; end
      chk(!bad, "R8 no retrigger on steady carrier", bad, 0);
      chk(tx_nib == 4'd0, "R8 pattern idle", tx_nib, 0);
      crs = 1'b0; full_duplex = 1'b1;
      tick();
      crs = 1'b1;
      bad = 1'b0;
      repeat (20) begin tick(); if (force_en) bad = 1'b1; end
      chk(!bad, "R8 none in full duplex", bad, 0);
      crs = 1'b0; full_duplex = 1'b0; bp_en = 1'b0;
      tick();
      crs = 1'b1;
      bad = 1'b0;
      repeat (20) begin tick(); if (force_en) bad = 1'b1; end
      chk(!bad, "R8 none when disabled", bad, 0);
      crs = 1'b0;
      tick();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule